// File: doc/BRIEF.md
# Sync-to-Framed Video Stream Converter

This block sits between a classic pixel-timing video source and a framed image input. The source side has horizontal sync, vertical sync, data enable and pixel data, all qualified by a per-cycle clock enable. The framed side has a valid strobe and four markers: start of frame, start of line, end of line and end of frame. A pixel counts only when the clock enable and the data enable are both high and neither sync is active. Blanking cycles therefore never produce a beat, even when the clock enable stays high. The source can throttle the output by lowering the clock enable on any cycle, including in the middle of a line. This stretches the line and loses no pixels.

The last pixel of a line is only known once the line has ended. For that reason each accepted pixel waits in a one-entry hold register. The held pixel leaves on the clock edge at which the next accepted pixel arrives, with no end marker. If instead the first clock-enabled cycle after the line arrives with data enable low or a sync active, the held pixel leaves on that cycle with the end-of-line marker. That beat counts as the line's own pixel, so every marker rides an asserted valid. A line counter, cleared by each vertical sync, is compared with a configured active height so that the last pixel of that line also carries end of frame.

The control path is a three-state machine:
- UNLOCKED is entered by reset and discards everything.
- GAP is between lines with nothing held. UNLOCKED goes to GAP on the active-going vertical sync edge.
- HOLD is inside a line with one pixel held. GAP goes to HOLD on an accepted pixel. HOLD stays in HOLD on the next accepted pixel, which emits the held one, and returns to GAP on a clock-enabled blanking cycle, which emits the held pixel with end of line.

Top module: `vidfrm_conv`

## Requirements
- R1: A synchronous reset drives every output to 0 and clears the machine to UNLOCKED. No beat is produced until the first active-going vertical sync edge after reset. Pixels presented before that edge are discarded.
- R2: A pixel is accepted only on a cycle with clock enable 1, data enable 1, and both syncs inactive. Data enable high during a sync pulse, or on a cycle with clock enable 0, never yields a beat. Every beat follows a cycle whose clock enable was 1.
- R3: Every accepted pixel after lock appears exactly once on the output, in arrival order, with its data unchanged. This holds however the clock enable is dropped within a line.
- R4: An accepted pixel is held, and appears on the output (registered) at the clock edge that samples the next accepted pixel of the same line. The edge that captures a pixel does not emit that pixel.
- R5: Start of line is set on the first pixel of each line. End of line is set on the last pixel of each line, emitted at the first clock-enabled cycle whose data enable is 0 or whose sync is active. That cycle may come later than the fall of data enable. A one-pixel line carries both markers on one beat.
- R6: Start of frame is set only on the first pixel of the first line after each vertical sync edge, and always together with start of line.
- R7: With configured height H (H ≥ 1), end of frame is set together with end of line on the last pixel of the H-th line after the vertical sync edge, and on no other beat. With H = 0, end of frame is never set.
- R8: While valid is 0, all four markers are 0 and the pixel output keeps its last value.
- R9: A polarity bit of 1 makes that sync active-high, and 0 makes it active-low (bit `cfg_hs_pol` for horizontal, `cfg_vs_pol` for vertical). A vertical sync that stays active for several cycles re-arms start of frame only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hs_pol | input | 1 | Horizontal sync polarity, 1 = active high |
| cfg_vs_pol | input | 1 | Vertical sync polarity, 1 = active high |
| cfg_height | input | HEIGHT_W | Active lines per frame; 0 disables end of frame |
| in_ce | input | 1 | Per-cycle clock enable qualifying all inputs |
| in_hs | input | 1 | Horizontal sync level |
| in_vs | input | 1 | Vertical sync level |
| in_de | input | 1 | Data enable |
| in_pix | input | PIX_W | Pixel data |
| out_valid | output | 1 | Beat strobe |
| out_sof | output | 1 | Start of frame marker |
| out_sol | output | 1 | Start of line marker |
| out_eol | output | 1 | End of line marker |
| out_eof | output | 1 | End of frame marker |
| out_pix | output | PIX_W | Pixel data of the beat |

## Verification
The assertions and the reference model take four things for granted about the source:
- At least one clock-enabled cycle falls between the end of one line and the first pixel of the next.
- The vertical sync edge comes only after the last line has been flushed.
- The configured height changes only during the vertical sync pulse.
- The polarity bits change only around a reset.

The stimulus keeps within these limits. It forces the clock enable high on the first cycle of each horizontal sync pulse and on the two cycles that open vertical blanking. It writes the height while the vertical sync is active, and it changes polarity only before a reset. Within those limits, the clock enable pattern inside lines, the line widths (down to one pixel), the line counts and the height (including zero and smaller than the line count) are random.

// File: rtl/vidfrm_pkg.sv
package vidfrm_pkg;

    localparam int NUM_SYNC = 2;
    localparam int SYNC_H   = 0;
    localparam int SYNC_V   = 1;

    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_GAP      = 2'd1,
        ST_HOLD     = 2'd2
    } line_state_e;

    typedef struct packed {
        logic sof;
        logic sol;
        logic eol;
        logic eof;
    } marks_t;

endpackage

// File: rtl/vidfrm_sync_norm.sv
module vidfrm_sync_norm (
    input  logic raw_lvl,
    input  logic act_high,
    output logic active
);
    // Level matches the selected active polarity.
    assign active = ~(raw_lvl ^ act_high);
endmodule

// File: rtl/vidfrm_line_ctl.sv
module vidfrm_line_ctl
    import vidfrm_pkg::*;
#(
    parameter int HEIGHT_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_ce,
    input  logic                in_de,
    input  logic                hs_act,
    input  logic                vs_act,
    input  logic [HEIGHT_W-1:0] cfg_height,
    output logic                load,
    output logic                emit,
    output logic                emit_eol,
    output logic                emit_eof,
    output logic                load_sol,
    output logic                load_sof
);
    localparam int CW = HEIGHT_W + 1;

    line_state_e         state, nxt;
    logic                vs_prev;
    logic                vs_edge;
    logic                sof_pend;
    logic [HEIGHT_W-1:0] lines_done;
    logic [CW-1:0]       line_num;
    logic                active_px;
    logic                eof_now;

    assign vs_edge   = vs_act & ~vs_prev;
    assign active_px = in_de & ~hs_act & ~vs_act;
    assign line_num  = {1'b0, lines_done} + CW'(1);
    assign eof_now   = (line_num == {1'b0, cfg_height});

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_UNLOCKED;
        else     state <= nxt;
    end

    // Next state and control outputs.
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        emit     = 1'b0;
        emit_eol = 1'b0;
        load_sol = 1'b0;
        load_sof = 1'b0;
        unique case (state)
            ST_UNLOCKED: begin
                if (vs_edge) nxt = ST_GAP;
            end
            ST_GAP: begin
                if (in_ce && active_px) begin
                    load     = 1'b1;
                    load_sol = 1'b1;
                    load_sof = sof_pend;
                    nxt      = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (in_ce) begin
                    emit = 1'b1;
                    if (active_px) begin
                        load = 1'b1;
                    end else begin
                        emit_eol = 1'b1;
                        nxt      = ST_GAP;
                    end
                end
            end
            default: nxt = ST_UNLOCKED;
        endcase
        emit_eof = emit_eol & eof_now;
    end

    // Frame bookkeeping: sync edge, start-of-frame arming, line count.
    always_ff @(posedge clk) begin
        if (rst) begin
            vs_prev    <= 1'b1;
            sof_pend   <= 1'b0;
            lines_done <= '0;
        end else begin
            vs_prev <= vs_act;
            if (vs_edge) begin
                sof_pend   <= 1'b1;
                lines_done <= '0;
            end else begin
                if (load_sof) sof_pend <= 1'b0;
                if (emit_eol && (lines_done != '1))
                    lines_done <= lines_done + HEIGHT_W'(1);
            end
        end
    end

endmodule

// File: rtl/vidfrm_hold_out.sv
module vidfrm_hold_out
    import vidfrm_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             emit,
    input  logic             emit_eol,
    input  logic             emit_eof,
    input  logic             load_sol,
    input  logic             load_sof,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output marks_t           out_marks,
    output logic [PIX_W-1:0] out_pix
);
    logic [PIX_W-1:0] hold_pix;
    logic             hold_sol;
    logic             hold_sof;

    // One-entry hold register.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_pix <= '0;
            hold_sol <= 1'b0;
            hold_sof <= 1'b0;
        end else if (load) begin
            hold_pix <= in_pix;
            hold_sol <= load_sol;
            hold_sof <= load_sof;
        end
    end

    // Output register; data only moves on a beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_marks <= '0;
            out_pix   <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_pix       <= hold_pix;
                out_marks.sof <= hold_sof;
                out_marks.sol <= hold_sol;
                out_marks.eol <= emit_eol;
                out_marks.eof <= emit_eof;
            end else begin
                out_marks <= '0;
            end
        end
    end

endmodule

// File: rtl/vidfrm_conv.sv
module vidfrm_conv
    import vidfrm_pkg::*;
#(
    parameter int PIX_W    = 24,
    parameter int HEIGHT_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_hs_pol,
    input  logic                cfg_vs_pol,
    input  logic [HEIGHT_W-1:0] cfg_height,
    input  logic                in_ce,
    input  logic                in_hs,
    input  logic                in_vs,
    input  logic                in_de,
    input  logic [PIX_W-1:0]    in_pix,
    output logic                out_valid,
    output logic                out_sof,
    output logic                out_sol,
    output logic                out_eol,
    output logic                out_eof,
    output logic [PIX_W-1:0]    out_pix
);
    logic [NUM_SYNC-1:0] sync_raw, sync_pol, sync_act;
    logic   load, emit, emit_eol, emit_eof, load_sol, load_sof;
    marks_t marks;

    assign sync_raw[SYNC_H] = in_hs;
    assign sync_raw[SYNC_V] = in_vs;
    assign sync_pol[SYNC_H] = cfg_hs_pol;
    assign sync_pol[SYNC_V] = cfg_vs_pol;

    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
        vidfrm_sync_norm u_norm (
            .raw_lvl  (sync_raw[g]),
            .act_high (sync_pol[g]),
            .active   (sync_act[g])
        );
    end

    vidfrm_line_ctl #(.HEIGHT_W(HEIGHT_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .in_ce      (in_ce),
        .in_de      (in_de),
        .hs_act     (sync_act[SYNC_H]),
        .vs_act     (sync_act[SYNC_V]),
        .cfg_height (cfg_height),
        .load       (load),
        .emit       (emit),
        .emit_eol   (emit_eol),
        .emit_eof   (emit_eof),
        .load_sol   (load_sol),
        .load_sof   (load_sof)
    );

    vidfrm_hold_out #(.PIX_W(PIX_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .emit      (emit),
        .emit_eol  (emit_eol),
        .emit_eof  (emit_eof),
        .load_sol  (load_sol),
        .load_sof  (load_sof),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_marks (marks),
        .out_pix   (out_pix)
    );

    assign out_sof = marks.sof;
    assign out_sol = marks.sol;
    assign out_eol = marks.eol;
    assign out_eof = marks.eof;

endmodule

// File: rtl/vidfrm_conv_chk.sv
module vidfrm_conv_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ce,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_sol,
    input logic             out_eol,
    input logic             out_eof,
    input logic [PIX_W-1:0] out_pix
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    assert_beat_needs_ce_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_ce));

    assert_sof_with_sol_R6: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_sol);

    assert_eof_with_eol_R7: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_eol);

    assert_marks_low_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_sof || out_sol || out_eol || out_eof));

    assert_pix_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_pix));
endmodule

bind vidfrm_conv vidfrm_conv_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ce     (in_ce),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_sol   (out_sol),
    .out_eol   (out_eol),
    .out_eof   (out_eof),
    .out_pix   (out_pix)
);

// File: tb/vidfrm_conv_tb.sv
module vidfrm_conv_tb;
    localparam int PIX_W    = 24;
    localparam int HEIGHT_W = 12;
    localparam int BW       = PIX_W + 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1;
    logic [HEIGHT_W-1:0] cfg_height = '0;
    logic                in_ce = 1'b0, in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
    logic [PIX_W-1:0]    in_pix = '0;
    logic                out_valid, out_sof, out_sol, out_eol, out_eof;
    logic [PIX_W-1:0]    out_pix;

    int n_chk = 0, n_bad = 0, beats = 0;
    bit armed = 0, done = 0;
    logic [BW-1:0]    exp_q[$];
    logic [PIX_W-1:0] last_pix = '0;

    always #10 clk = ~clk;

    vidfrm_conv #(.PIX_W(PIX_W), .HEIGHT_W(HEIGHT_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
        .cfg_height(cfg_height), .in_ce(in_ce), .in_hs(in_hs), .in_vs(in_vs),
        .in_de(in_de), .in_pix(in_pix), .out_valid(out_valid), .out_sof(out_sof),
        .out_sol(out_sol), .out_eol(out_eol), .out_eof(out_eof), .out_pix(out_pix)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic phys(bit act, logic pol);
        return pol ? act : ~act;
    endfunction

    function automatic logic [BW-1:0] beat(logic [PIX_W-1:0] p, bit sof, bit sol, bit eol, bit eof);
        return {p, sof, sol, eol, eof};
    endfunction

    task automatic cyc(bit ce, bit hs, bit vs, bit de, logic [PIX_W-1:0] pix);
        @(negedge clk);
        in_ce  = ce;
        in_hs  = phys(hs, cfg_hs_pol);
        in_vs  = phys(vs, cfg_vs_pol);
        in_de  = de;
        in_pix = pix;
    endtask

    function automatic logic [PIX_W-1:0] rpix();
        return PIX_W'($urandom);
    endfunction

    // Output monitor: scoreboard for beats, idle rules otherwise.
    always @(posedge clk) begin
        #5;
        if (rst) begin
            last_pix = '0;
        end else if (out_valid) begin
            beats++;
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected beat", 64'(out_pix), 64'(0));
            end else begin
                logic [BW-1:0] e;
                e = exp_q.pop_front();
                chk(beat(out_pix, out_sof, out_sol, out_eol, out_eof) == e, "R3 beat data/markers",
                    64'(beat(out_pix, out_sof, out_sol, out_eol, out_eof)), 64'(e));
            end
            last_pix = out_pix;
        end else begin
            chk({out_sof, out_sol, out_eol, out_eof} == 4'b0 && out_pix == last_pix, "R8 idle outputs",
                64'({out_pix, out_sof, out_sol, out_eol, out_eof}), 64'({last_pix, 4'b0}));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        in_ce = 1'b0; in_de = 1'b0;
        in_hs = phys(0, cfg_hs_pol);
        in_vs = phys(0, cfg_vs_pol);
        repeat (3) @(negedge clk);
        chk({out_valid, out_sof, out_sol, out_eol, out_eof} == 5'b0 && out_pix == '0, "R1 reset outputs",
            64'({out_valid, out_pix}), 64'(0));
        rst   = 1'b0;
        armed = 0;
        exp_q.delete();
    endtask

    // Flush previous line, then vertical sync pulse (with a data enable glitch).
    task automatic vblank(int h);
        cyc(1, 0, 0, 0, rpix());
        cyc(1, 0, 0, 0, rpix());
        cyc(1, 0, 1, 1, rpix());   // R2: data enable during vsync is ignored
        cfg_height = HEIGHT_W'(h);
        armed = 1;
        cyc(0, 0, 1, 0, rpix());
        cyc(1, 0, 1, 0, rpix());   // R9: long pulse arms only once
        cyc(1, 0, 0, 0, rpix());
        cyc($urandom_range(1, 0), 0, 0, 0, rpix());
    endtask

    task automatic hblank();
        for (int k = 0; k < int'($urandom_range(2, 0)); k++) cyc($urandom_range(1, 0), 0, 0, 0, rpix());
        cyc(1, 1, 0, 0, rpix());
        cyc(1, 1, 0, 1, rpix());   // R2: data enable during hsync is ignored
        cyc($urandom_range(1, 0), 1, 0, 0, rpix());
        cyc($urandom_range(1, 0), 0, 0, 0, rpix());
    endtask

    task automatic send_line(int w, int l, int h, int ce_pct);
        for (int i = 0; i < w; ) begin
            if (int'($urandom_range(99, 0)) < ce_pct) begin
                logic [PIX_W-1:0] p;
                p = rpix();
                if (armed)
                    exp_q.push_back(beat(p, l == 0 && i == 0, i == 0, i == w - 1,
                                         i == w - 1 && l + 1 == h));
                cyc(1, 0, 0, 1, p);
                i++;
            end else begin
                cyc(0, 0, 0, 1, rpix());
            end
        end
    endtask

    task automatic frame(int w_max, int lines, int h, int ce_pct);
        vblank(h);
        for (int l = 0; l < lines; l++) begin
            send_line(int'($urandom_range(w_max, 1)), l, h, ce_pct);
            hblank();
        end
    endtask

    // Two pixels of a line, then reset: only the first may come out.
    task automatic partial_then_reset();
        logic [PIX_W-1:0] a;
        a = rpix();
        exp_q.push_back(beat(a, 0, 1, 0, 0));
        cyc(1, 0, 0, 1, a);
        cyc(1, 0, 0, 1, rpix());
        cyc(0, 0, 0, 0, rpix());
        @(posedge clk); #6;
        chk(exp_q.size() == 0, "R3 first pixel out before reset", 64'(exp_q.size()), 64'(0));
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R1: no lock yet, a whole line is discarded.
        send_line(6, 0, 1, 100);
        hblank();
        repeat (4) @(negedge clk);
        chk(beats == 0, "R1 no beats before vsync", 64'(beats), 64'(0));

        // Directed timing: height 1, two-pixel line.
        begin
            logic [PIX_W-1:0] pa, pb;
            pa = 24'hA1A1A1; pb = 24'hB2B2B2;
            vblank(1);
            exp_q.push_back(beat(pa, 1, 1, 0, 0));
            exp_q.push_back(beat(pb, 0, 0, 1, 1));
            cyc(1, 0, 0, 1, pa);
            @(posedge clk); #2;
            chk(out_valid == 1'b0, "R4 captured pixel not yet out", 64'(out_valid), 64'(0));
            cyc(1, 0, 0, 1, pb);
            @(posedge clk); #2;
            chk(out_valid && out_pix == pa, "R4 held pixel out on next pixel", 64'({out_valid, out_pix}), 64'({1'b1, pa}));
            chk(out_sof && out_sol && !out_eol, "R6 first pixel markers", 64'({out_sof, out_sol, out_eol}), 64'(3'b110));
            cyc(0, 0, 0, 0, rpix());
            @(posedge clk); #2;
            chk(out_valid == 1'b0, "R5 end of line waits for clock enable", 64'(out_valid), 64'(0));
            cyc(1, 0, 0, 0, rpix());
            @(posedge clk); #2;
            chk(out_valid && out_pix == pb && out_eol, "R5 last pixel with end of line", 64'({out_valid, out_eol, out_pix}), 64'({2'b11, pb}));
            chk(out_eof == 1'b1, "R7 end of frame on line 1 of height 1", 64'(out_eof), 64'(1));
            hblank();
        end

        // Random frames under each polarity setting.
        for (int ph = 0; ph < 4; ph++) begin
            cfg_hs_pol = ph[0];
            cfg_vs_pol = ph[1];
            do_reset();
            for (int f = 0; f < 4; f++) begin
                int lines, h, sel;
                lines = int'($urandom_range(5, 2));
                sel   = int'($urandom_range(2, 0));
                h     = (sel == 0) ? lines : (sel == 1) ? lines - 1 : 0;
                if (f == 0) h = lines;
                frame((f == 1) ? 1 : 9, lines, h, int'($urandom_range(100, 30)));
            end
            partial_then_reset();
        end

        // Final frame then flush; every pixel must have come out.
        do_reset();
        frame(7, 3, 3, 50);
        vblank(0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all pixels delivered", 64'(exp_q.size()), 64'(0));
        chk(beats > 100, "R9 traffic seen under all polarities", 64'(beats), 64'(101));

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule